// File: doc/BRIEF.md
# Event-Driven Multi-Output PWM Timer

This block is a free-running up-counter that feeds a shared pool of match events, which in turn drive a bank of output pins. Every event compares the counter against one chosen match register. Every output holds two event masks: one names the events that raise the pin, the other names the events that lower it. A per-output rule decides what happens when a raise and a lower land on the same count. A limit mask names the events that send the counter back to zero, so a single event sets the period that all outputs share. Each output then sets its duty with an event of its own.

Software programs the block through a word-wide register port. Writes take effect on the next clock edge. Reads return data one cycle after the request. Each match register has a shadow reload register. Unless a freeze bit is set, every match register copies its shadow at each limit wrap, so a new duty written to the shadow takes effect on a period boundary. Writing a match register directly changes it at once. The counter is clocked through a programmable prescaler and can be halted. Reset leaves the block halted with every output low.

Top module: `evt_pwm_timer`

## Requirements
- R1: After reset every register reads 0 except the run register, which reads 1 (halted), and every pwmOut bit is 0. Asserting rstN at any time returns the block to this state.
- R2: Register map, all word aligned: mode 0x000 (bit 0 freeze); run 0x004 (bit 0 halt, bits 15:8 prescale); limit mask 0x008; resolve 0x00C; match n at 0x100+4n; reload n at 0x140+4n; event n at 0x200+4n (bits 3:0 source match index, bit 8 enable); output n raise mask at 0x300+8n and lower mask at 0x304+8n. A read pulse on busRe returns the addressed value on busRdata with rdValid in the following cycle. Unmapped or misaligned addresses read 0.
- R3: While halt is 1, the counter and every output hold their values.
- R4: With prescale value P and halt 0, the counter advances once every P+1 clocks, and outputs change only on those advances.
- R5: Event n fires on an advance when its enable bit is 1 and the match register chosen by its source field equals the counter. Any event may select any match register.
- R6: If any fired event is in the limit mask, the counter becomes 0 at that advance instead of incrementing. A limit match of M gives a period of M+1 advances.
- R7: On an advance, an output that receives only a raise becomes 1, one that receives only a lower becomes 0, and one that receives neither holds its value. With raise on the limit event and lower on a duty match D (D<M), the pin is high for D+1 of every M+1 advances. With the two masks swapped (inverted), it is high for M−D advances.
- R8: When an output receives a raise and a lower on the same advance, resolve bits 2n+1:2n decide its value: 0 holds, 1 drives 1, 2 drives 0, 3 inverts.
- R9: With freeze 0, every match register loads its reload register on each advance in which the counter wraps on a limit event. A direct write to a match register takes effect at once.
- R10: With freeze 1, match registers keep their values across wraps.
- R11: An event with enable 0 never fires, so an output that depends on it for lowering stays high once raised.
- R12: Several outputs run at once with different duties over the shared period, each keeping its own ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busWe | input | 1 | Register write strobe |
| busRe | input | 1 | Register read strobe |
| busAddr | input | 10 | Byte address of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with rdValid |
| rdValid | output | 1 | Read data valid, one cycle after busRe |
| pwmOut | output | 16 | Output pins |

## Verification
An output's raise and lower can arrive on the same advance. The bench provokes this by giving one output a duty match equal to the period match, so both of its events fire on the wrap count. It then programs each of the four resolve codes in turn and counts high cycles over a fixed window: all high for drive-1 and for hold after drive-1, none for drive-0, and half for invert. A second case where two paths meet in one cycle is a wrap reload racing a direct match write. The bench separates the two by halting before the direct write and reading the register back on both sides of the next wrap.

// File: rtl/evt_pwm_pkg.sv
package evt_pwm_pkg;

  // Width of a match-register index carried in events and slot writes.
  localparam int SEL_W  = 4;
  // Width of the register port data word.
  localparam int WORD_W = 32;

  // Per-output rule for a coincident raise and lower.
  typedef enum logic [1:0] {
    RES_HOLD  = 2'd0,
    RES_SET   = 2'd1,
    RES_CLEAR = 2'd2,
    RES_FLIP  = 2'd3
  } resolve_e;

  // Strobes from the register control to the counting datapath.
  typedef struct packed {
    logic              matchWe;
    logic              reloadWe;
    logic [SEL_W-1:0]  slot;
    logic [WORD_W-1:0] value;
  } slotWrite_t;

endpackage

// File: rtl/evt_pwm_regs.sv
module evt_pwm_regs
  import evt_pwm_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8,
  parameter int ADDR_W  = 10
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busWe,
  input  logic                busRe,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWdata,
  output logic [WORD_W-1:0]   busRdata,
  output logic                rdValid,
  output slotWrite_t          slotWr,
  output logic                haltQ,
  output logic [PRE_W-1:0]    preQ,
  output logic                freezeQ,
  output logic [NUM_EVT-1:0]  limitQ,
  output logic [2*NUM_OUT-1:0] resolveQ,
  output logic [SEL_W-1:0]    evSel   [NUM_EVT],
  output logic [NUM_EVT-1:0]  evEn,
  output logic [NUM_EVT-1:0]  setMask [NUM_OUT],
  output logic [NUM_EVT-1:0]  clrMask [NUM_OUT],
  input  logic [CNT_W-1:0]    matchRd [NUM_EVT],
  input  logic [CNT_W-1:0]    reloadRd[NUM_EVT]
);

  localparam int OSEL_W = (NUM_OUT > 1) ? $clog2(NUM_OUT) : 1;
  localparam int EN_BIT  = 8;
  localparam int PRE_LSB = 8;

  localparam logic [ADDR_W-1:0] ADR_MODE    = ADDR_W'(32'h000);
  localparam logic [ADDR_W-1:0] ADR_RUN     = ADDR_W'(32'h004);
  localparam logic [ADDR_W-1:0] ADR_LIMIT   = ADDR_W'(32'h008);
  localparam logic [ADDR_W-1:0] ADR_RESOLVE = ADDR_W'(32'h00C);
  localparam logic [ADDR_W-1:0] BASE_MATCH  = ADDR_W'(32'h100);
  localparam logic [ADDR_W-1:0] BASE_RELOAD = ADDR_W'(32'h100 + 4 * NUM_EVT);
  localparam logic [ADDR_W-1:0] BASE_EVENT  = ADDR_W'(32'h200);
  localparam logic [ADDR_W-1:0] BASE_OUT    = ADDR_W'(32'h300);
  localparam logic [ADDR_W-1:0] SLOT_SPAN   = ADDR_W'(4 * NUM_EVT);
  localparam logic [ADDR_W-1:0] OUT_SPAN    = ADDR_W'(8 * NUM_OUT);

  logic [ADDR_W-1:0] offMatch, offReload, offEvent, offOut;
  logic aligned, hitMatch, hitReload, hitEvent, hitOut;
  logic [SEL_W-1:0]  matchIdx, reloadIdx, evIdx;
  logic [OSEL_W-1:0] outIdx;
  logic              outLower;
  logic [WORD_W-1:0] rdMux;

  assign offMatch  = busAddr - BASE_MATCH;
  assign offReload = busAddr - BASE_RELOAD;
  assign offEvent  = busAddr - BASE_EVENT;
  assign offOut    = busAddr - BASE_OUT;
  assign aligned   = (busAddr[1:0] == 2'b00);

  assign hitMatch  = aligned && (busAddr >= BASE_MATCH)  && (offMatch  < SLOT_SPAN);
  assign hitReload = aligned && (busAddr >= BASE_RELOAD) && (offReload < SLOT_SPAN);
  assign hitEvent  = aligned && (busAddr >= BASE_EVENT)  && (offEvent  < SLOT_SPAN);
  assign hitOut    = aligned && (busAddr >= BASE_OUT)    && (offOut    < OUT_SPAN);

  assign matchIdx  = offMatch[SEL_W+1:2];
  assign reloadIdx = offReload[SEL_W+1:2];
  assign evIdx     = offEvent[SEL_W+1:2];
  assign outIdx    = offOut[OSEL_W+2:3];
  assign outLower  = offOut[2];

  // Strobes toward the datapath, which owns match and reload storage.
  always_comb begin
    slotWr.matchWe  = busWe && hitMatch;
    slotWr.reloadWe = busWe && hitReload;
    slotWr.slot     = hitMatch ? matchIdx : reloadIdx;
    slotWr.value    = busWdata;
  end

  // Configuration storage.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      haltQ    <= 1'b1;
      preQ     <= '0;
      freezeQ  <= 1'b0;
      limitQ   <= '0;
      resolveQ <= '0;
      evEn     <= '0;
      for (int e = 0; e < NUM_EVT; e++) evSel[e] <= '0;
      for (int o = 0; o < NUM_OUT; o++) begin
        setMask[o] <= '0;
        clrMask[o] <= '0;
      end
    end else if (busWe) begin
      if (busAddr == ADR_MODE) freezeQ <= busWdata[0];
      if (busAddr == ADR_RUN) begin
        haltQ <= busWdata[0];
        preQ  <= busWdata[PRE_LSB +: PRE_W];
      end
      if (busAddr == ADR_LIMIT)   limitQ   <= busWdata[NUM_EVT-1:0];
      if (busAddr == ADR_RESOLVE) resolveQ <= busWdata[2*NUM_OUT-1:0];
      if (hitEvent) begin
        evSel[evIdx] <= busWdata[SEL_W-1:0];
        evEn[evIdx]  <= busWdata[EN_BIT];
      end
      if (hitOut) begin
        if (outLower) clrMask[outIdx] <= busWdata[NUM_EVT-1:0];
        else          setMask[outIdx] <= busWdata[NUM_EVT-1:0];
      end
    end
  end

  // Read selection.
  always_comb begin
    rdMux = '0;
    if (busAddr == ADR_MODE) begin
      rdMux[0] = freezeQ;
    end else if (busAddr == ADR_RUN) begin
      rdMux[0] = haltQ;
      rdMux[PRE_LSB +: PRE_W] = preQ;
    end else if (busAddr == ADR_LIMIT) begin
      rdMux[NUM_EVT-1:0] = limitQ;
    end else if (busAddr == ADR_RESOLVE) begin
      rdMux[2*NUM_OUT-1:0] = resolveQ;
    end else if (hitMatch) begin
      rdMux[CNT_W-1:0] = matchRd[matchIdx];
    end else if (hitReload) begin
      rdMux[CNT_W-1:0] = reloadRd[reloadIdx];
    end else if (hitEvent) begin
      rdMux[SEL_W-1:0] = evSel[evIdx];
      rdMux[EN_BIT]    = evEn[evIdx];
    end else if (hitOut) begin
      rdMux[NUM_EVT-1:0] = outLower ? clrMask[outIdx] : setMask[outIdx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid  <= 1'b0;
      busRdata <= '0;
    end else begin
      rdValid <= busRe;
      if (busRe) busRdata <= rdMux;
    end
  end

endmodule

// File: rtl/evt_pwm_outcell.sv
module evt_pwm_outcell
  import evt_pwm_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       setHit,
  input  logic       clrHit,
  input  logic [1:0] rule,
  output logic       level
);

  logic nxt;

  always_comb begin
    nxt = level;
    if (setHit && clrHit) begin
      case (resolve_e'(rule))
        RES_SET:   nxt = 1'b1;
        RES_CLEAR: nxt = 1'b0;
        RES_FLIP:  nxt = ~level;
        default:   nxt = level;
      endcase
    end else if (setHit) begin
      nxt = 1'b1;
    end else if (clrHit) begin
      nxt = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) level <= 1'b0;
    else       level <= nxt;
  end

endmodule

// File: rtl/evt_pwm_core.sv
module evt_pwm_core
  import evt_pwm_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  slotWrite_t           slotWr,
  input  logic                 haltQ,
  input  logic [PRE_W-1:0]     preQ,
  input  logic                 freezeQ,
  input  logic [NUM_EVT-1:0]   limitQ,
  input  logic [2*NUM_OUT-1:0] resolveQ,
  input  logic [SEL_W-1:0]     evSel   [NUM_EVT],
  input  logic [NUM_EVT-1:0]   evEn,
  input  logic [NUM_EVT-1:0]   setMask [NUM_OUT],
  input  logic [NUM_EVT-1:0]   clrMask [NUM_OUT],
  output logic [CNT_W-1:0]     matchQ  [NUM_EVT],
  output logic [CNT_W-1:0]     reloadQ [NUM_EVT],
  output logic [CNT_W-1:0]     countQ,
  output logic                 tick,
  output logic                 limitHit,
  output logic [NUM_OUT-1:0]   pwmOut
);

  logic [PRE_W-1:0]   preCnt;
  logic [NUM_EVT-1:0] fire;
  logic               doReload;

  // Prescaler: one advance every preQ+1 clocks while running.
  assign tick = !haltQ && (preCnt == preQ);

  always_ff @(posedge clk) begin
    if (!rstN || haltQ || tick) preCnt <= '0;
    else                        preCnt <= preCnt + 1'b1;
  end

  // Event pool.
  for (genvar e = 0; e < NUM_EVT; e++) begin : gEvt
    assign fire[e] = tick && evEn[e] && (matchQ[evSel[e]] == countQ);
  end

  assign limitHit = |(fire & limitQ);
  assign doReload = tick && limitHit && !freezeQ;

  always_ff @(posedge clk) begin
    if (!rstN)     countQ <= '0;
    else if (tick) countQ <= limitHit ? '0 : countQ + 1'b1;
  end

  // Match / reload pairs; a direct match write beats a wrap reload.
  for (genvar s = 0; s < NUM_EVT; s++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchQ[s]  <= '0;
        reloadQ[s] <= '0;
      end else begin
        if (slotWr.matchWe && slotWr.slot == SEL_W'(s))
          matchQ[s] <= slotWr.value[CNT_W-1:0];
        else if (doReload)
          matchQ[s] <= reloadQ[s];
        if (slotWr.reloadWe && slotWr.slot == SEL_W'(s))
          reloadQ[s] <= slotWr.value[CNT_W-1:0];
      end
    end
  end

  // Output bank.
  for (genvar o = 0; o < NUM_OUT; o++) begin : gOut
    logic setHit, clrHit;
    assign setHit = |(fire & setMask[o]);
    assign clrHit = |(fire & clrMask[o]);
    evt_pwm_outcell uCell (
      .clk    (clk),
      .rstN   (rstN),
      .setHit (setHit),
      .clrHit (clrHit),
      .rule   (resolveQ[2*o +: 2]),
      .level  (pwmOut[o])
    );
  end

endmodule

// File: rtl/evt_pwm_timer.sv
module evt_pwm_timer
  import evt_pwm_pkg::*;
#(
  parameter int NUM_EVT = 16,
  parameter int NUM_OUT = 16,
  parameter int CNT_W   = 32,
  parameter int PRE_W   = 8,
  parameter int ADDR_W  = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               busWe,
  input  logic               busRe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [WORD_W-1:0]  busWdata,
  output logic [WORD_W-1:0]  busRdata,
  output logic               rdValid,
  output logic [NUM_OUT-1:0] pwmOut
);

  slotWrite_t           slotWr;
  logic                 haltQ;
  logic [PRE_W-1:0]     preQ;
  logic                 freezeQ;
  logic [NUM_EVT-1:0]   limitQ;
  logic [2*NUM_OUT-1:0] resolveQ;
  logic [SEL_W-1:0]     evSel   [NUM_EVT];
  logic [NUM_EVT-1:0]   evEn;
  logic [NUM_EVT-1:0]   setMask [NUM_OUT];
  logic [NUM_EVT-1:0]   clrMask [NUM_OUT];
  logic [CNT_W-1:0]     matchQ  [NUM_EVT];
  logic [CNT_W-1:0]     reloadQ [NUM_EVT];
  logic [CNT_W-1:0]     countQ;
  logic                 tick;
  logic                 limitHit;

  evt_pwm_regs #(
    .NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT), .CNT_W(CNT_W),
    .PRE_W(PRE_W), .ADDR_W(ADDR_W)
  ) uRegs (
    .clk(clk), .rstN(rstN),
    .busWe(busWe), .busRe(busRe), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rdValid(rdValid),
    .slotWr(slotWr), .haltQ(haltQ), .preQ(preQ), .freezeQ(freezeQ),
    .limitQ(limitQ), .resolveQ(resolveQ), .evSel(evSel), .evEn(evEn),
    .setMask(setMask), .clrMask(clrMask),
    .matchRd(matchQ), .reloadRd(reloadQ)
  );

  evt_pwm_core #(
    .NUM_EVT(NUM_EVT), .NUM_OUT(NUM_OUT), .CNT_W(CNT_W), .PRE_W(PRE_W)
  ) uCore (
    .clk(clk), .rstN(rstN), .slotWr(slotWr),
    .haltQ(haltQ), .preQ(preQ), .freezeQ(freezeQ),
    .limitQ(limitQ), .resolveQ(resolveQ), .evSel(evSel), .evEn(evEn),
    .setMask(setMask), .clrMask(clrMask),
    .matchQ(matchQ), .reloadQ(reloadQ), .countQ(countQ),
    .tick(tick), .limitHit(limitHit), .pwmOut(pwmOut)
  );

endmodule

// File: rtl/evt_pwm_timer_chk.sv
module evt_pwm_timer_chk #(
  parameter int CNT_W   = 32,
  parameter int NUM_OUT = 16
) (
  input logic               clk,
  input logic               rstN,
  input logic               busRe,
  input logic               rdValid,
  input logic [NUM_OUT-1:0] pwmOut,
  input logic               haltQ,
  input logic               tick,
  input logic               limitHit,
  input logic [CNT_W-1:0]   countQ
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rstN |=> (pwmOut == '0) && !rdValid);

  assert_read_follows_R2: assert property (@(posedge clk) disable iff (!rstN)
    busRe |=> rdValid);

  assert_no_stray_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |=> !rdValid);

  assert_halt_freeze_R3: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |=> $stable(pwmOut) && $stable(countQ));

  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !tick |=> $stable(pwmOut) && $stable(countQ));

  assert_wrap_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && limitHit) |=> (countQ == '0));

  assert_step_up_R6: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !limitHit) |=> (countQ == $past(countQ) + 1'b1));

endmodule

bind evt_pwm_timer evt_pwm_timer_chk #(.CNT_W(CNT_W), .NUM_OUT(NUM_OUT)) uChk (
  .clk(clk), .rstN(rstN), .busRe(busRe), .rdValid(rdValid), .pwmOut(pwmOut),
  .haltQ(haltQ), .tick(tick), .limitHit(limitHit), .countQ(countQ)
);

// File: tb/tb_evt_pwm_timer.sv
`timescale 1ns/1ps
module tb_evt_pwm_timer;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [9:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        rdValid;
  logic [15:0] pwmOut;

  int nChecks = 0;
  int nFails  = 0;

  logic [31:0] expQ[$];
  string       tagQ[$];
  logic [31:0] rdExp;
  string       rdTag;

  always #4 clk = ~clk;

  evt_pwm_timer dut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .rdValid(rdValid), .pwmOut(pwmOut)
  );

  function automatic logic [9:0] aMatch(int n);  return 10'(32'h100 + 4*n); endfunction
  function automatic logic [9:0] aReload(int n); return 10'(32'h140 + 4*n); endfunction
  function automatic logic [9:0] aEvent(int n);  return 10'(32'h200 + 4*n); endfunction
  function automatic logic [9:0] aRaise(int n);  return 10'(32'h300 + 8*n); endfunction
  function automatic logic [9:0] aLower(int n);  return 10'(32'h304 + 8*n); endfunction
  localparam logic [9:0] A_MODE = 10'h000, A_RUN = 10'h004,
                         A_LIMIT = 10'h008, A_RESOLVE = 10'h00C;

  // Scoreboard monitor for register reads.
  always @(negedge clk) begin
    if (rstN && rdValid) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R2 unexpected read data act=%h exp=none", busRdata);
      end else begin
        rdExp = expQ.pop_front();
        rdTag = tagQ.pop_front();
        if (busRdata !== rdExp) begin
          nFails++;
          $display("FAIL %s read act=%h exp=%h", rdTag, busRdata, rdExp);
        end
      end
    end
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rdExpect(input logic [9:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    busRe = 1'b1; busAddr = a;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic setSlot(input int n, input logic [31:0] v);
    wr(aMatch(n), v);
    wr(aReload(n), v);
  endtask

  task automatic checkEq(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic measureHigh(input int idx, input int cycles, output int hi);
    hi = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (pwmOut[idx]) hi++;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    #(8 * 150000);
    nChecks++;
    nFails++;
    $display("FAIL all watchdog expired act=running exp=done");
    summary();
    $finish;
  end

  initial begin
    int hi;
    logic [15:0] snap;
    int holdOk;

    // R1 reset state
    settle(5);
    rstN = 1'b1;
    settle(1);
    checkEq("R1 pwmOut after reset", int'(pwmOut), 0);
    rdExpect(A_RUN,     32'h1, "R1 run reg");
    rdExpect(A_MODE,    32'h0, "R1 mode reg");
    rdExpect(A_LIMIT,   32'h0, "R1 limit reg");
    rdExpect(A_RESOLVE, 32'h0, "R1 resolve reg");
    rdExpect(aMatch(3), 32'h0, "R1 match3");
    rdExpect(aEvent(2), 32'h0, "R1 event2");
    rdExpect(aRaise(1), 32'h0, "R1 raise mask1");

    // R2 register access
    wr(aMatch(7), 32'hDEADBEEF);
    rdExpect(aMatch(7), 32'hDEADBEEF, "R2 match7");
    wr(aReload(4), 32'h0001_2345);
    rdExpect(aReload(4), 32'h0001_2345, "R2 reload4");
    wr(aEvent(9), 32'h0000_010B);
    rdExpect(aEvent(9), 32'h0000_010B, "R2 event9 fields");
    wr(A_RESOLVE, 32'hFFFF_FFFF);
    rdExpect(A_RESOLVE, 32'hFFFF_FFFF, "R2 resolve");
    wr(aLower(6), 32'h0000_A5A5);
    rdExpect(aLower(6), 32'h0000_A5A5, "R2 lower mask6");
    rdExpect(10'h0F0, 32'h0, "R2 unmapped");
    rdExpect(10'h102, 32'h0, "R2 misaligned");
    wr(aEvent(9), 32'h0);
    wr(aLower(6), 32'h0);

    // Shared period M=9, duties on several outputs
    setSlot(0, 9);
    setSlot(1, 3);
    setSlot(2, 7);
    setSlot(5, 9);
    wr(aEvent(0), 32'h100);
    wr(aEvent(1), 32'h101);
    wr(aEvent(2), 32'h102);
    wr(aEvent(3), 32'h101);  // R5: event3 uses match1
    wr(aEvent(4), 32'h001);  // R11: selector set, enable off
    wr(aEvent(5), 32'h105);
    wr(aRaise(0), 32'h0001); wr(aLower(0), 32'h0002);
    wr(aRaise(1), 32'h0002); wr(aLower(1), 32'h0001);
    wr(aRaise(2), 32'h0001); wr(aLower(2), 32'h0004);
    wr(aRaise(3), 32'h0001); wr(aLower(3), 32'h0008);
    wr(aRaise(4), 32'h0001); wr(aLower(4), 32'h0010);
    wr(aRaise(5), 32'h0001); wr(aLower(5), 32'h0020);
    wr(A_LIMIT, 32'h1);
    wr(A_RESOLVE, 32'h0000_0400);  // out5 code 1
    wr(A_RUN, 32'h0);
    settle(30);

    measureHigh(0, 50, hi); checkEq("R7 R6 out0 normal duty", hi, 20);
    measureHigh(1, 50, hi); checkEq("R7 out1 inverted duty", hi, 30);
    measureHigh(2, 50, hi); checkEq("R12 out2 second duty", hi, 40);
    measureHigh(3, 50, hi); checkEq("R5 out3 via shared match", hi, 20);
    measureHigh(4, 50, hi); checkEq("R11 out4 disabled lower", hi, 50);

    // R8 coincident raise and lower on out5
    measureHigh(5, 50, hi); checkEq("R8 code1 drive high", hi, 50);
    wr(A_RESOLVE, 32'h0000_0000); settle(25);
    measureHigh(5, 50, hi); checkEq("R8 code0 hold", hi, 50);
    wr(A_RESOLVE, 32'h0000_0800); settle(25);
    measureHigh(5, 50, hi); checkEq("R8 code2 drive low", hi, 0);
    wr(A_RESOLVE, 32'h0000_0C00); settle(25);
    measureHigh(5, 100, hi); checkEq("R8 code3 invert", hi, 50);

    // R4 prescale of 1
    wr(A_RUN, 32'h0000_0101);
    wr(A_RUN, 32'h0000_0100);
    rdExpect(A_RUN, 32'h0000_0100, "R2 R4 prescale field");
    settle(45);
    measureHigh(0, 100, hi); checkEq("R4 out0 prescaled", hi, 40);
    measureHigh(1, 100, hi); checkEq("R4 out1 prescaled", hi, 60);
    wr(A_RUN, 32'h1);
    wr(A_RUN, 32'h0);
    settle(25);

    // R3 halt
    wr(A_RUN, 32'h1);
    settle(3);
    snap = pwmOut;
    holdOk = 1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (pwmOut !== snap) holdOk = 0;
    end
    checkEq("R3 outputs frozen while halted", holdOk, 1);

    // R9 direct write while halted, then reload at wrap
    wr(aMatch(1), 32'd5);
    rdExpect(aMatch(1), 32'd5, "R9 direct match write");
    wr(A_RUN, 32'h0);
    settle(25);
    rdExpect(aMatch(1), 32'd3, "R9 reload at wrap");

    // R10 freeze
    wr(A_MODE, 32'h1);
    wr(aReload(1), 32'd6);
    settle(25);
    rdExpect(aMatch(1), 32'd3, "R10 frozen match");
    measureHigh(0, 50, hi); checkEq("R10 duty unchanged", hi, 20);

    wr(A_MODE, 32'h0);
    settle(25);
    rdExpect(aMatch(1), 32'd6, "R9 reload after unfreeze");
    measureHigh(0, 50, hi); checkEq("R9 duty from reload", hi, 35);
    settle(3);

    // R1 reset while running
    @(negedge clk);
    rstN = 1'b0;
    settle(2);
    checkEq("R1 pwmOut in reset", int'(pwmOut), 0);
    rstN = 1'b1;
    settle(1);
    rdExpect(A_RUN,     32'h1, "R1 run after reset");
    rdExpect(aMatch(0), 32'h0, "R1 match0 after reset");
    settle(4);

    if (expQ.size() != 0) begin
      nChecks++;
      nFails++;
      $display("FAIL R2 missing read data act=%0d exp=0 pending", expQ.size());
    end
    summary();
    $finish;
  end

endmodule